// File: doc/BRIEF.md
# MSI Receive Interrupt Collector

This block sits inside a PCIe endpoint. It turns inbound message-signalled interrupt writes into one interrupt event for the local CPU. Any remote agent can raise an interrupt by writing a vector number, either the root complex or a peer endpoint. The write arrives on a dedicated inbound trigger port or through the trigger register of the local register bus. The vector sets one pending bit. Vector `v` selects group `v mod 8` and bit `v div 8` inside that group. Eight groups of four bits cover vectors 0 to 31.

Local software uses a word-addressed register bus with combinational read data. It reads each group's raw and masked status, clears pending bits by writing ones to the masked-status register, and changes enables through separate set and clear registers. Four scratch registers carry extra event information between agents and software. The masked pending bits of all groups are ORed together. A two-state event machine registers the result:

- `EV_IDLE` goes to `EV_ACTIVE` when any enabled pending bit exists.
- `EV_ACTIVE` goes back to `EV_IDLE` when none remains.
- Both states hold otherwise.
- `irq_event` is high exactly in `EV_ACTIVE`.

Address map: `bus_addr[5:3]` selects a region and `bus_addr[2:0]` selects an index within it.

| Region | Addresses | Contents |
|---|---|---|
| 0 | 0 | Trigger register |
| 0 | 4..7 | Scratch registers 0..3 |
| 1 | 8 + g | Raw status of group g |
| 2 | 16 + g | Masked status of group g |
| 3 | 24 + g | Enable-set register of group g |
| 4 | 32 + g | Enable-clear register of group g |

Top module: `msi_irq_collector`

## Requirements
- R1: A trigger write, on `msi_wr_en` or by a bus write to address 0, uses only data bits [4:0] as vector v. It sets raw bit v[4:3] of group v[2:0], so vectors 0, 8, 16 and 24 land in group 0 as bits 0..3. Data bits [31:5] are ignored. Two triggers in the same cycle both take effect.
- R2: Reading address 8+g returns group g's raw pending bits in data bits [3:0], with zeros above. Raw bits only change on a trigger, a clear or a reset.
- R3: Reading address 16+g returns group g's raw bits ANDed with its enable mask.
- R4: Writing 1 to a bit of address 16+g clears that raw bit whether or not it is enabled. Writing 0 changes nothing.
- R5: Writing 1 to a bit at 24+g sets that enable bit, and writing 1 at 32+g clears it. A 0 leaves the bit unchanged. Reading either address returns the current enable mask.
- R6: Raw bits latch while their enable is off. Setting the enable later raises the event.
- R7: `irq_event` rises on the clock edge after an enabled pending bit first exists. It falls on the edge after the last one is cleared or disabled.
- R8: When a trigger and a clear hit the same bit in the same cycle, the bit ends set. A clear of other bits in that cycle still applies.
- R9: Addresses 4..7 are 32-bit read/write scratch registers. They have no effect on status, enables or `irq_event`.
- R10: While `rst_n` is low, all raw bits, enables and scratch registers are zero and `irq_event` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_wr_en | input | 1 | Inbound trigger write strobe |
| msi_wr_data | input | 32 | Inbound trigger data, vector in bits [4:0] |
| bus_addr | input | 6 | Local register word address |
| bus_wdata | input | 32 | Local write data |
| bus_we | input | 1 | Local write enable |
| bus_rdata | output | 32 | Local read data, combinational from `bus_addr` |
| irq_event | output | 1 | Aggregated, registered interrupt event |

## Verification
The hardest case to reach is a race between a remote trigger and a local clear on the same bit in the same cycle. One register bus cannot produce that race, so the bench drives the inbound trigger port and a masked-status clear on the bus in the same cycle. It then reads the raw status and the event back. A second same-cycle case sends two triggers, one on each source. It checks that both bits land.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;

    localparam int DATA_W      = 32;
    localparam int NUM_GROUPS  = 8;
    localparam int GRP_BITS    = 4;
    localparam int NUM_GPR     = 4;

    // Region field taken from the upper address bits.
    typedef enum logic [2:0] {
        RGN_CTRL = 3'd0,
        RGN_RAW  = 3'd1,
        RGN_MSK  = 3'd2,
        RGN_ENS  = 3'd3,
        RGN_ENC  = 3'd4
    } region_e;

    typedef enum logic [0:0] {
        EV_IDLE   = 1'b0,
        EV_ACTIVE = 1'b1
    } ev_state_e;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_irq_pkg::*;
#(
    parameter int NGRP   = 8,
    parameter int NGPR   = 4,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    output logic              trig_wr,
    output logic [NGPR-1:0]   gpr_wr,
    output logic [NGRP-1:0]   msk_wr,
    output logic [NGRP-1:0]   ens_wr,
    output logic [NGRP-1:0]   enc_wr
);

    localparam int RGN_W = ADDR_W - IDX_W;

    logic [RGN_W-1:0] rgn;
    logic [IDX_W-1:0] idx;

    assign rgn = bus_addr[ADDR_W-1:IDX_W];
    assign idx = bus_addr[IDX_W-1:0];

    always_comb begin
        trig_wr = 1'b0;
        gpr_wr  = '0;
        msk_wr  = '0;
        ens_wr  = '0;
        enc_wr  = '0;
        if (bus_we) begin
            case (rgn)
                RGN_W'(RGN_CTRL): begin
                    if (idx == '0) begin
                        trig_wr = 1'b1;
                    end
                    for (int k = 0; k < NGPR; k++) begin
                        if (int'(idx) == NGPR + k) gpr_wr[k] = 1'b1;
                    end
                end
                RGN_W'(RGN_MSK): begin
                    for (int g = 0; g < NGRP; g++) begin
                        if (int'(idx) == g) msk_wr[g] = 1'b1;
                    end
                end
                RGN_W'(RGN_ENS): begin
                    for (int g = 0; g < NGRP; g++) begin
                        if (int'(idx) == g) ens_wr[g] = 1'b1;
                    end
                end
                RGN_W'(RGN_ENC): begin
                    for (int g = 0; g < NGRP; g++) begin
                        if (int'(idx) == g) enc_wr[g] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: a single bus write never drives more than one register strobe
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_wr, gpr_wr, msk_wr, ens_wr, enc_wr}));

endmodule

// File: rtl/msi_group.sv
module msi_group #(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_bits,
    input  logic             msk_wr,
    input  logic             ens_wr,
    input  logic             enc_wr,
    input  logic [NBITS-1:0] wbits,
    output logic [NBITS-1:0] raw_q,
    output logic [NBITS-1:0] en_q
);

    logic [NBITS-1:0] clr_bits;

    assign clr_bits = msk_wr ? wbits : '0;

    // A new vector overrides a clear of the same bit in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | set_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (ens_wr) begin
            en_q <= en_q | wbits;
        end else if (enc_wr) begin
            en_q <= en_q & ~wbits;
        end
    end

    // R1
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((raw_q & $past(set_bits)) == $past(set_bits)));

    // R4
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_bits & ~set_bits)) |=> ((raw_q & $past(clr_bits & ~set_bits)) == '0));

    // R5
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_wr |=> ((en_q & $past(wbits)) == '0));

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ens_wr |=> ((en_q & $past(wbits)) == $past(wbits)));

endmodule

// File: rtl/msi_event_fsm.sv
module msi_event_fsm
    import msi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    output logic irq_event
);

    ev_state_e state_q;
    ev_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:   if (pend_any)  state_d = EV_ACTIVE;
            EV_ACTIVE: if (!pend_any) state_d = EV_IDLE;
            default:   state_d = EV_IDLE;
        endcase
    end

    always_comb begin
        irq_event = (state_q == EV_ACTIVE);
    end

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |=> irq_event);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_any |=> !irq_event);

endmodule

// File: rtl/msi_irq_collector.sv
module msi_irq_collector
    import msi_irq_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int NGRP  = NUM_GROUPS,
    parameter int NBITS = GRP_BITS,
    parameter int NGPR  = NUM_GPR,
    localparam int GSEL_W = $clog2(NGRP),
    localparam int BSEL_W = (NBITS > 1) ? $clog2(NBITS) : 1,
    localparam int GPR_IW = $clog2(2 * NGPR),
    localparam int IDX_W  = (GSEL_W > GPR_IW) ? GSEL_W : GPR_IW,
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_wr_en,
    input  logic [DW-1:0]     msi_wr_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_event
);

    localparam int VEC_W = GSEL_W + BSEL_W;

    logic              trig_wr;
    logic [NGPR-1:0]   gpr_wr;
    logic [NGRP-1:0]   msk_wr;
    logic [NGRP-1:0]   ens_wr;
    logic [NGRP-1:0]   enc_wr;
    logic [NBITS-1:0]  set_bits [NGRP];
    logic [NBITS-1:0]  raw_q    [NGRP];
    logic [NBITS-1:0]  en_q     [NGRP];
    logic [NGRP-1:0]   grp_pend;
    logic [DW-1:0]     gpr_q    [NGPR];
    logic [VEC_W-1:0]  rmt_vec;
    logic [VEC_W-1:0]  loc_vec;
    logic [2:0]        rgn;
    logic [IDX_W-1:0]  idx;

    assign rmt_vec = msi_wr_data[VEC_W-1:0];
    assign loc_vec = bus_wdata[VEC_W-1:0];
    assign rgn     = bus_addr[ADDR_W-1:IDX_W];
    assign idx     = bus_addr[IDX_W-1:0];

    msi_reg_decode #(
        .NGRP   (NGRP),
        .NGPR   (NGPR),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .trig_wr  (trig_wr),
        .gpr_wr   (gpr_wr),
        .msk_wr   (msk_wr),
        .ens_wr   (ens_wr),
        .enc_wr   (enc_wr)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar b = 0; b < NBITS; b++) begin : g_bit
            assign set_bits[g][b] =
                (msi_wr_en && rmt_vec == VEC_W'(b * NGRP + g)) ||
                (trig_wr   && loc_vec == VEC_W'(b * NGRP + g));
        end

        msi_group #(
            .NBITS (NBITS)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_bits[g]),
            .msk_wr   (msk_wr[g]),
            .ens_wr   (ens_wr[g]),
            .enc_wr   (enc_wr[g]),
            .wbits    (bus_wdata[NBITS-1:0]),
            .raw_q    (raw_q[g]),
            .en_q     (en_q[g])
        );

        assign grp_pend[g] = |(raw_q[g] & en_q[g]);
    end

    for (genvar k = 0; k < NGPR; k++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gpr_q[k] <= '0;
            end else if (gpr_wr[k]) begin
                gpr_q[k] <= bus_wdata;
            end
        end
    end

    msi_event_fsm u_ev (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_any  (|grp_pend),
        .irq_event (irq_event)
    );

    always_comb begin
        bus_rdata = '0;
        case (rgn)
            RGN_CTRL: begin
                for (int k = 0; k < NGPR; k++) begin
                    if (int'(idx) == NGPR + k) bus_rdata = gpr_q[k];
                end
            end
            RGN_RAW: begin
                for (int g = 0; g < NGRP; g++) begin
                    if (int'(idx) == g) bus_rdata = DW'(raw_q[g]);
                end
            end
            RGN_MSK: begin
                for (int g = 0; g < NGRP; g++) begin
                    if (int'(idx) == g) bus_rdata = DW'(raw_q[g] & en_q[g]);
                end
            end
            RGN_ENS, RGN_ENC: begin
                for (int g = 0; g < NGRP; g++) begin
                    if (int'(idx) == g) bus_rdata = DW'(en_q[g]);
                end
            end
            default: ;
        endcase
    end

    // R8
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_wr_en && msk_wr[rmt_vec[GSEL_W-1:0]] &&
         bus_wdata[rmt_vec[VEC_W-1:GSEL_W]])
        |=> raw_q[$past(rmt_vec[GSEL_W-1:0])][$past(rmt_vec[VEC_W-1:GSEL_W])]);

    // R9
    gpr_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gpr_wr) && !msi_wr_en) |=> $stable(grp_pend));

endmodule

// File: tb/tb_msi_irq_collector.sv
module tb_msi_irq_collector;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msi_wr_en;
    logic [31:0] msi_wr_data;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;
    logic        irq_event;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    msi_irq_collector dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .msi_wr_en   (msi_wr_en),
        .msi_wr_data (msi_wr_data),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_rdata   (bus_rdata),
        .irq_event   (irq_event)
    );

    // Entry: {req[3:0], kind[1:0], addr[5:0], data[31:0], exp[31:0]}
    // kind 0: bus write; 1: bus read and compare; 2: one cycle, then compare irq_event
    localparam int NT = 38;
    localparam logic [75:0] TBL [NT] = '{
        {4'd1,  2'd0, 6'd0,  32'hFFFF_FFE0, 32'h0},        // R1 vector 0, high bits ignored
        {4'd2,  2'd1, 6'd8,  32'h0,         32'h1},        // R2
        {4'd6,  2'd2, 6'd0,  32'h0,         32'h0},        // R6 latched, not enabled
        {4'd1,  2'd0, 6'd0,  32'h8,         32'h0},        // R1 vector 8
        {4'd1,  2'd0, 6'd0,  32'h10,        32'h0},        // R1 vector 16
        {4'd1,  2'd0, 6'd0,  32'h18,        32'h0},        // R1 vector 24
        {4'd1,  2'd1, 6'd8,  32'h0,         32'hF},        // R1 all in group 0
        {4'd3,  2'd1, 6'd16, 32'h0,         32'h0},        // R3 masked is empty
        {4'd5,  2'd0, 6'd24, 32'h5,         32'h0},        // R5 enable bits 0,2
        {4'd5,  2'd1, 6'd24, 32'h0,         32'h5},        // R5
        {4'd5,  2'd1, 6'd32, 32'h0,         32'h5},        // R5
        {4'd3,  2'd1, 6'd16, 32'h0,         32'h5},        // R3
        {4'd6,  2'd2, 6'd0,  32'h0,         32'h1},        // R6 event after enable
        {4'd5,  2'd0, 6'd24, 32'h0,         32'h0},        // R5 zero write
        {4'd5,  2'd1, 6'd24, 32'h0,         32'h5},        // R5
        {4'd5,  2'd0, 6'd32, 32'h1,         32'h0},        // R5 disable bit 0
        {4'd5,  2'd1, 6'd32, 32'h0,         32'h4},        // R5
        {4'd3,  2'd1, 6'd16, 32'h0,         32'h4},        // R3
        {4'd4,  2'd0, 6'd16, 32'h0,         32'h0},        // R4 zero write
        {4'd4,  2'd1, 6'd8,  32'h0,         32'hF},        // R4
        {4'd4,  2'd0, 6'd16, 32'h4,         32'h0},        // R4 clear bit 2
        {4'd4,  2'd1, 6'd8,  32'h0,         32'hB},        // R4
        {4'd7,  2'd2, 6'd0,  32'h0,         32'h0},        // R7 event falls
        {4'd4,  2'd0, 6'd16, 32'h1,         32'h0},        // R4 clear disabled bit
        {4'd4,  2'd1, 6'd8,  32'h0,         32'hA},        // R4
        {4'd1,  2'd0, 6'd0,  32'h1F,        32'h0},        // R1 vector 31
        {4'd1,  2'd1, 6'd15, 32'h0,         32'h8},        // R1 group 7 bit 3
        {4'd1,  2'd1, 6'd14, 32'h0,         32'h0},        // R1 group 6 empty
        {4'd5,  2'd0, 6'd31, 32'h8,         32'h0},        // R5 enable group 7
        {4'd7,  2'd2, 6'd0,  32'h0,         32'h1},        // R7 event rises
        {4'd9,  2'd0, 6'd4,  32'hDEAD_BEEF, 32'h0},        // R9
        {4'd9,  2'd1, 6'd4,  32'h0,         32'hDEAD_BEEF},// R9
        {4'd9,  2'd0, 6'd7,  32'h1234_5678, 32'h0},        // R9
        {4'd9,  2'd1, 6'd7,  32'h0,         32'h1234_5678},// R9
        {4'd9,  2'd1, 6'd15, 32'h0,         32'h8},        // R9 status untouched
        {4'd5,  2'd0, 6'd39, 32'h8,         32'h0},        // R5 disable group 7
        {4'd7,  2'd2, 6'd0,  32'h0,         32'h0},        // R7 event falls
        {4'd6,  2'd1, 6'd15, 32'h0,         32'h8}         // R6 raw kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input string req, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n       = 1'b0;
        msi_wr_en   = 1'b0;
        msi_wr_data = '0;
        bus_addr    = '0;
        bus_wdata   = '0;
        bus_we      = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10", {31'b0, irq_event}, 32'h0);
        for (int g = 0; g < 8; g++) bus_read("R10", 6'(8 + g), 32'h0);
        bus_read("R10", 6'd24, 32'h0);
        bus_read("R10", 6'd5, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NT; i++) begin
            automatic logic [3:0]  rq = TBL[i][75:72];
            automatic logic [1:0]  kd = TBL[i][71:70];
            automatic logic [5:0]  ad = TBL[i][69:64];
            automatic logic [31:0] dt = TBL[i][63:32];
            automatic logic [31:0] ex = TBL[i][31:0];
            automatic string tag = $sformatf("R%0d", rq);
            if (kd == 2'd0) begin
                bus_write(ad, dt);
            end else if (kd == 2'd1) begin
                bus_read(tag, ad, ex);
            end else begin
                @(posedge clk);
                @(negedge clk);
                check(tag, {31'b0, irq_event}, ex);
            end
        end

        // R8 same-cycle trigger and clear of the same bit (vector 5 = group 5 bit 0)
        msi_wr_en   = 1'b1;
        msi_wr_data = 32'd5;
        @(posedge clk);
        @(negedge clk);
        msi_wr_en = 1'b0;
        bus_write(6'd29, 32'h3);
        msi_wr_en   = 1'b1;
        msi_wr_data = 32'd5;
        bus_write(6'd21, 32'h1);
        msi_wr_en = 1'b0;
        bus_read("R8", 6'd13, 32'h1);
        @(posedge clk);
        @(negedge clk);
        check("R8", {31'b0, irq_event}, 32'h1);

        // R8 trigger vector 13 (group 5 bit 1) while clearing bit 0
        msi_wr_en   = 1'b1;
        msi_wr_data = 32'd13;
        bus_write(6'd21, 32'h1);
        msi_wr_en = 1'b0;
        bus_read("R8", 6'd13, 32'h2);

        // R1 two triggers in one cycle: remote vector 6, local vector 14
        msi_wr_en   = 1'b1;
        msi_wr_data = 32'hFFFF_FFE6;
        bus_write(6'd0, 32'd14);
        msi_wr_en = 1'b0;
        bus_read("R1", 6'd14, 32'h3);

        // R10 reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10", {31'b0, irq_event}, 32'h0);
        bus_read("R10", 6'd13, 32'h0);
        bus_read("R10", 6'd37, 32'h0);
        bus_read("R10", 6'd4, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end

endmodule